// File: doc/BRIEF.md
# Byte-Bus Atomic Access Bridge for 16-bit Timer Registers

This block sits between an 8-bit peripheral bus and four 16-bit timer registers. The four registers are a free-running counter, two compare values and a capture value. Each register is reached through two byte addresses. One shared byte-wide holding register makes each 16-bit transfer atomic.

For a write, software writes the high byte first. That byte only lands in the holding register. The following low-byte write then commits all sixteen bits of the target register on one clock edge. For a read, software reads the low byte first. That access returns the live low byte and, on the same edge, freezes the target's high byte into the holding register. The later high-byte read returns the frozen byte, so both halves of the result come from the same cycle.

All four registers share the one holding byte. Any access that touches it between the two halves of another access therefore corrupts that access. The bridge keeps this behaviour on purpose and does not protect against it. Around the bridge sit a simple counter increment input and an external capture strobe.

Top module: `tmr16_byte_bridge`

## Requirements
- R1: On a synchronous active-high reset, the holding byte and all four 16-bit registers become zero.
- R2: Register k (0 = counter, 1 = compare A, 2 = compare B, 3 = capture) has its low byte at address 2k and its high byte at address 2k+1. A write to a high-byte address loads only the holding byte and leaves all four registers unchanged.
- R3: A write to a low-byte address loads the target register with {holding byte, bus byte} on one edge. Writing 0x01 to address 1 and then 0xFF to address 0 gives a counter of 0x01FF.
- R4: A read of a low-byte address returns the target's current bits [7:0] combinationally. On the same edge it copies the target's bits [15:8] into the holding byte.
- R5: A read of a high-byte address returns the holding byte and does not change it.
- R6: One holding byte serves all four registers. An access to any register between the two halves of another access changes the value the second half uses.
- R7: While cnt_inc is high, the counter adds one per cycle and wraps at 0xFFFF. A low-byte write to the counter in the same cycle wins over the increment.
- R8: When cap_strobe is high, the capture register loads the counter value from before that edge. This takes priority over a bus write to the capture register in the same cycle.
- R9: Addresses 8 and above are unmapped. Reads of them return zero. Writes and reads to them change neither the registers nor the holding byte.
- R10: When wr_en and rd_en are both high, only the write affects state. The read's snapshot into the holding byte is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (4) | Byte address |
| wdata | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data byte, combinational, zero when not reading a mapped address |
| cnt_inc | input | 1 | Counter increment request |
| cap_strobe | input | 1 | Capture event |
| cnt_val | output | 16 | Counter contents |
| cmp_a | output | 16 | Compare A contents |
| cmp_b | output | 16 | Compare B contents |
| cap_val | output | 16 | Capture contents |

## Verification
The bench builds the bridge with its default parameters: a 4-bit address and the map based at address zero. With these values half the address space is unmapped, so the zero-read and no-effect rules can be exercised next to every mapped byte. A behavioural model tracks the holding byte and all four registers every cycle. Directed sequences cover these cases:
- interleaved accesses that corrupt the shared byte;
- a write colliding with the increment;
- a capture colliding with a write;
- a simultaneous read and write.

A long pseudo-random run then mixes every address with the increment and capture inputs.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NREG    = 4;
    localparam int IDX_W   = $clog2(NREG);

    localparam int CNT_IDX  = 0;
    localparam int CMPA_IDX = 1;
    localparam int CMPB_IDX = 2;
    localparam int CAP_IDX  = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        byte_t                 hold;
        word_t [NREG-1:0]      regs;
    } bank_t;
endpackage

// File: rtl/tmr16_decode.sv
module tmr16_decode
    import tmr16_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ADDR_BASE = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_hi,
    output logic [IDX_W-1:0]  sel
);
    logic [NREG-1:0] lo_match;
    logic [NREG-1:0] hi_match;

    for (genvar g = 0; g < NREG; g++) begin : g_match
        assign lo_match[g] = (addr == ADDR_W'(ADDR_BASE + 2 * g));
        assign hi_match[g] = (addr == ADDR_W'(ADDR_BASE + 2 * g + 1));
    end

    always_comb begin
        hit   = |{hi_match, lo_match};
        is_hi = |hi_match;
        sel   = '0;
        for (int i = 0; i < NREG; i++) begin
            if (lo_match[i] || hi_match[i]) begin
                sel = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tmr16_regfile.sv
module tmr16_regfile
    import tmr16_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic             rd_lo,
    input  logic [IDX_W-1:0] sel,
    input  byte_t            wdata,
    input  logic             cnt_inc,
    input  logic             cap_strobe,
    output word_t [NREG-1:0] regs,
    output byte_t            hold
);
    bank_t bank_d;
    bank_t bank_q;

    always_comb begin
        bank_d = bank_q;
        // Shared holding byte: parked high byte on write, frozen high byte on read.
        if (wr_hi) begin
            bank_d.hold = wdata;
        end else if (rd_lo) begin
            bank_d.hold = bank_q.regs[sel][WORD_W-1:BYTE_W];
        end
        for (int i = 0; i < NREG; i++) begin
            if (i == CNT_IDX && cnt_inc) begin
                bank_d.regs[i] = bank_q.regs[i] + 1'b1;
            end
            if (wr_lo && sel == IDX_W'(i)) begin
                bank_d.regs[i] = {bank_q.hold, wdata};
            end
            if (i == CAP_IDX && cap_strobe) begin
                bank_d.regs[i] = bank_q.regs[CNT_IDX];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs = bank_q.regs;
    assign hold = bank_q.hold;

    // R2: high-byte write parks data in the holding byte only
    a_r2_hold_loads: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> hold == $past(wdata));

    // R3: low-byte write to compare A commits the full word
    a_r3_cmpa_commit: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && sel == IDX_W'(CMPA_IDX)) |=> regs[CMPA_IDX] == {$past(hold), $past(wdata)});

    // R4: low-byte read freezes the target's high byte
    a_r4_snapshot: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !wr_hi) |=> hold == $past(regs[sel][WORD_W-1:BYTE_W]));

    // R7: counter write wins over increment
    a_r7_write_beats_inc: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && sel == IDX_W'(CNT_IDX)) |=> regs[CNT_IDX] == {$past(hold), $past(wdata)});

    // R7: increment alone adds one
    a_r7_increment: assert property (@(posedge clk) disable iff (rst)
        (cnt_inc && !(wr_lo && sel == IDX_W'(CNT_IDX))) |=> regs[CNT_IDX] == $past(regs[CNT_IDX]) + 1'b1);

    // R8: capture takes the pre-edge counter value
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        cap_strobe |=> regs[CAP_IDX] == $past(regs[CNT_IDX]));
endmodule

// File: rtl/tmr16_byte_bridge.sv
module tmr16_byte_bridge
    import tmr16_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ADDR_BASE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic              cnt_inc,
    input  logic              cap_strobe,
    output logic [15:0]       cnt_val,
    output logic [15:0]       cmp_a,
    output logic [15:0]       cmp_b,
    output logic [15:0]       cap_val
);
    logic             hit;
    logic             is_hi;
    logic [IDX_W-1:0] sel;
    logic             wr_hi;
    logic             wr_lo;
    logic             rd_lo;
    word_t [NREG-1:0] regs;
    byte_t            hold;

    tmr16_decode #(
        .ADDR_W    (ADDR_W),
        .ADDR_BASE (ADDR_BASE)
    ) u_decode (
        .addr  (addr),
        .hit   (hit),
        .is_hi (is_hi),
        .sel   (sel)
    );

    assign wr_hi = wr_en && hit && is_hi;
    assign wr_lo = wr_en && hit && !is_hi;
    assign rd_lo = rd_en && !wr_en && hit && !is_hi;

    tmr16_regfile u_regfile (
        .clk        (clk),
        .rst        (rst),
        .wr_hi      (wr_hi),
        .wr_lo      (wr_lo),
        .rd_lo      (rd_lo),
        .sel        (sel),
        .wdata      (wdata),
        .cnt_inc    (cnt_inc),
        .cap_strobe (cap_strobe),
        .regs       (regs),
        .hold       (hold)
    );

    always_comb begin
        rdata = '0;
        if (rd_en && hit) begin
            rdata = is_hi ? hold : regs[sel][BYTE_W-1:0];
        end
    end

    assign cnt_val = regs[CNT_IDX];
    assign cmp_a   = regs[CMPA_IDX];
    assign cmp_b   = regs[CMPB_IDX];
    assign cap_val = regs[CAP_IDX];

    // R9: unmapped reads return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |-> rdata == '0);

    // R9: unmapped accesses leave every register and the holding byte alone
    a_r9_unmapped_inert: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_en) && !hit && !cnt_inc && !cap_strobe)
        |=> ($stable(regs) && $stable(hold)));

    // R5: a high-byte read leaves the holding byte alone
    a_r5_hi_read_stable: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && hit && is_hi) |=> $stable(hold));

    // R10: a read with a concurrent write never snapshots
    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !(hit && is_hi)) |=> $stable(hold));
endmodule

// File: tb/tmr16_byte_bridge_test.sv
module tmr16_byte_bridge_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic       wr_en;
    logic       rd_en;
    logic [7:0] rdata;
    logic       cnt_inc;
    logic       cap_strobe;
    logic [15:0] cnt_val, cmp_a, cmp_b, cap_val;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    int m_reg [4];
    int m_hold;

    always #5 clk = ~clk;

    tmr16_byte_bridge uut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .cnt_inc(cnt_inc), .cap_strobe(cap_strobe),
        .cnt_val(cnt_val), .cmp_a(cmp_a), .cmp_b(cmp_b), .cap_val(cap_val)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) m_reg[i] = 0;
            m_hold = 0;
        end else begin
            int old_cnt;
            int nxt [4];
            int idx;
            old_cnt = m_reg[0];
            for (int i = 0; i < 4; i++) nxt[i] = m_reg[i];
            idx = int'(addr) / 2;
            if (cnt_inc) nxt[0] = (m_reg[0] + 1) % 65536;
            if (wr_en && addr < 8 && addr[0] == 1'b0) nxt[idx] = m_hold * 256 + int'(wdata);
            if (cap_strobe) nxt[3] = old_cnt;
            if (wr_en && addr < 8 && addr[0] == 1'b1) m_hold = int'(wdata);
            else if (rd_en && !wr_en && addr < 8 && addr[0] == 1'b0) m_hold = m_reg[idx] / 256;
            for (int i = 0; i < 4; i++) m_reg[i] = nxt[i];
        end
    end

    task automatic check(input string tag, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
        end
    endtask

    // Per-cycle model comparison
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("MODEL cnt R7", int'(cnt_val), m_reg[0]);
            check("MODEL cmpA R3", int'(cmp_a), m_reg[1]);
            check("MODEL cmpB R3", int'(cmp_b), m_reg[2]);
            check("MODEL cap R8", int'(cap_val), m_reg[3]);
        end
    end

    function automatic int exp_rdata(input logic rd, input logic [3:0] a);
        if (!rd || a >= 8) return 0;
        if (a[0]) return m_hold;
        return m_reg[int'(a) / 2] % 256;
    endfunction

    task automatic op(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d,
                      input logic inc, input logic cap, input string tag);
        @(negedge clk);
        #2;
        wr_en = w; rd_en = r; addr = a; wdata = d; cnt_inc = inc; cap_strobe = cap;
        #1;
        if (r) check({tag, " rdata"}, int'(rdata), exp_rdata(r, a));
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; cnt_inc = 1'b0; cap_strobe = 1'b0; addr = '0; wdata = '0;
    endtask

    // Read returns the byte seen on the bus
    task automatic rd_byte(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        #2;
        rd_en = 1'b1; addr = a;
        #1;
        v = rdata;
        @(posedge clk);
        #1;
        rd_en = 1'b0; addr = '0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
        cnt_inc = 1'b0; cap_strobe = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values
        check("R1 cnt", int'(cnt_val), 0);
        check("R1 cmpA", int'(cmp_a), 0);
        check("R1 cmpB", int'(cmp_b), 0);
        check("R1 cap", int'(cap_val), 0);
        rd_byte(4'd1, v);
        check("R1 hold", int'(v), 0);

        // R2 / R3: high byte then low byte
        op(1, 0, 4'd1, 8'h01, 0, 0, "R2");
        check("R2 counter untouched", int'(cnt_val), 0);
        op(1, 0, 4'd0, 8'hFF, 0, 0, "R3");
        check("R3 counter 0x01FF", int'(cnt_val), 16'h01FF);
        op(1, 0, 4'd3, 8'hAB, 0, 0, "R2");
        op(1, 0, 4'd2, 8'hCD, 0, 0, "R3");
        check("R3 cmpA", int'(cmp_a), 16'hABCD);

        // R4 / R5: low read then high read
        rd_byte(4'd0, v);
        check("R4 low byte", int'(v), 8'hFF);
        rd_byte(4'd1, v);
        check("R5 high byte from hold", int'(v), 8'h01);
        rd_byte(4'd1, v);
        check("R5 hold unchanged by high read", int'(v), 8'h01);

        // R6: interleaved access corrupts the pending write
        op(1, 0, 4'd5, 8'h12, 0, 0, "R6");
        op(0, 1, 4'd2, 8'h00, 0, 0, "R6");
        op(1, 0, 4'd4, 8'h34, 0, 0, "R6");
        check("R6 cmpB corrupted", int'(cmp_b), 16'hAB34);

        // R7: increment, then write beats increment
        op(0, 0, 4'd0, 8'h00, 1, 0, "R7");
        op(0, 0, 4'd0, 8'h00, 1, 0, "R7");
        check("R7 counter +2", int'(cnt_val), 16'h0201);
        op(1, 0, 4'd1, 8'h50, 1, 0, "R7");
        op(1, 0, 4'd0, 8'h00, 1, 0, "R7");
        check("R7 write wins", int'(cnt_val), 16'h5000);
        op(1, 0, 4'd1, 8'hFF, 0, 0, "R7");
        op(1, 0, 4'd0, 8'hFF, 0, 0, "R7");
        op(0, 0, 4'd0, 8'h00, 1, 0, "R7");
        check("R7 wrap", int'(cnt_val), 0);

        // R8: capture, and capture beats bus write
        op(1, 0, 4'd1, 8'h12, 0, 0, "R8");
        op(1, 0, 4'd0, 8'h34, 0, 0, "R8");
        op(0, 0, 4'd0, 8'h00, 1, 1, "R8");
        check("R8 capture pre-edge counter", int'(cap_val), 16'h1234);
        op(1, 0, 4'd7, 8'h77, 0, 0, "R8");
        op(1, 0, 4'd6, 8'h66, 0, 1, "R8");
        check("R8 strobe beats write", int'(cap_val), 16'h1235);

        // R9: unmapped addresses
        op(1, 0, 4'd1, 8'h5A, 0, 0, "R9");
        op(1, 0, 4'd9, 8'hC3, 0, 0, "R9");
        op(1, 0, 4'd8, 8'h3C, 0, 0, "R9");
        rd_byte(4'd12, v);
        check("R9 unmapped read zero", int'(v), 0);
        rd_byte(4'd1, v);
        check("R9 hold untouched", int'(v), 8'h5A);
        check("R9 counter untouched", int'(cnt_val), 16'h1235);

        // R10: simultaneous read and write on counter low byte
        op(1, 1, 4'd0, 8'h99, 0, 0, "R10");
        check("R10 write applied", int'(cnt_val), 16'h5A99);
        rd_byte(4'd1, v);
        check("R10 no snapshot", int'(v), 8'h5A);

        // Mixed pseudo-random traffic against the model
        for (int n = 0; n < 600; n++) begin
            logic [3:0] a;
            logic [7:0] d;
            logic w, r, inc, cap;
            a   = 4'($urandom_range(0, 15));
            d   = 8'($urandom_range(0, 255));
            w   = 1'($urandom_range(0, 1));
            r   = 1'($urandom_range(0, 1));
            inc = 1'($urandom_range(0, 1));
            cap = ($urandom_range(0, 7) == 0);
            op(w, r, a, d, inc, cap, "MIX R6");
        end

        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule